// File: doc/BRIEF.md
# Software-Allocated Prefetch Read Buffer

This block is a small store that software fills on purpose ahead of a loop that reads the data. It holds four entries, each one memory line of eight 32-bit words. An allocation command names the entry to use, a byte address and a size of one word, four words or eight words. The command goes into a short queue and the caller moves on at once. A fetch engine takes commands from the queue in the order they arrived, clears the chosen entry, gives it the new line tag, and reads the words from memory one at a time.

Each word has its own valid bit. A word becomes valid only when its data comes back, so a partly filled entry can serve exactly the words it holds. A load presents an address every cycle if it needs to. One cycle later the block answers with a hit flag and, on a hit, the word. A miss returns zero and the load takes the normal cache path. An entry keeps its data until software sends a new allocation to that same entry.

Top module: `pfrb_top`

## Requirements
- R1: After synchronous reset, no word in any entry is valid, `alloc_busy` is low, `mem_req` is low and `ld_rsp_valid` is low.
- R2: Size code 0 fetches one word, code 1 fetches four words, and codes 2 and 3 both fetch eight words. Within one command the words are read in ascending address order.
- R3: A four-word allocation ignores address bits [3:0] and fetches the 16-byte aligned group that holds the address.
- R4: A full-line allocation ignores address bits [4:0] and fetches the 32-byte aligned line.
- R5: A one-word allocation fetches the word at address bits [31:2], and every `mem_addr` is word aligned (bits [1:0] zero).
- R6: Only words that were fetched can hit. A load to another word of the same line misses.
- R7: When the fetch engine starts a command, the target entry loses every valid bit and takes the new tag before any word returns.
- R8: Each cycle with `ld_valid` high produces `ld_rsp_valid` on the next cycle. When some entry holds that line and that word is valid, `ld_hit` is 1 and `ld_data` is the word. Otherwise `ld_hit` is 0 and `ld_data` is 0. Back-to-back loads give one answer per clock.
- R9: Memory reads go out in the order the allocation commands were accepted.
- R10: The queue holds four commands. While it is full, `alloc_busy` is high and an offered allocation is dropped with no effect on any entry.
- R11: An entry keeps its valid words when other entries are allocated. Only a new allocation to that entry changes it.
- R12: A load whose line matches an entry but whose word has not yet returned misses. The same load hits once the word has arrived.
- R13: While `mem_req` is high and `mem_rvalid` is low, `mem_req` stays high and `mem_addr` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Allocation command offered this cycle |
| alloc_entry | input | 2 | Entry that the command fills |
| alloc_addr | input | 32 | Byte address of the data to prefetch |
| alloc_size | input | 2 | 0 one word, 1 four words, 2 or 3 eight words |
| alloc_busy | output | 1 | Queue full; an offered command is dropped |
| ld_valid | input | 1 | Load lookup this cycle |
| ld_addr | input | 32 | Byte address of the load |
| ld_rsp_valid | output | 1 | Lookup result is present |
| ld_hit | output | 1 | Load hit a valid word |
| ld_data | output | 32 | Word read on a hit, zero on a miss |
| mem_req | output | 1 | Word read request to memory |
| mem_addr | output | 32 | Word-aligned byte address of the read |
| mem_rvalid | input | 1 | Read data returned; completes the request |
| mem_rdata | input | 32 | Returned read data |

## Verification
The bench aims at the alignment corners: a four-word request placed in the upper half of a line and a full-line request with the low bits set. A design that did not drop those bits would fetch past the group it was asked for, and the memory-side scoreboard would flag the wrong address. It holds memory back so that an entry stays part-filled, then shows that a matching line with a missing word misses and later hits. A design that set all the valid bits at allocation time would hit early. It then fills the queue and offers one more command, which must be turned away. A design that dropped the command silently, or that stored it anyway, would either lack the busy flag or overwrite a line that must survive.

// File: rtl/pfrb_pkg.sv
package pfrb_pkg;

    localparam int ADDR_W     = 32;
    localparam int DATA_W     = 32;
    localparam int N_ENT      = 4;
    localparam int LINE_WORDS = 8;
    localparam int HALF_WORDS = 4;
    localparam int Q_DEPTH    = 4;

    localparam int ENT_W    = $clog2(N_ENT);
    localparam int WIDX_W   = $clog2(LINE_WORDS);
    localparam int BYTE_OFF = $clog2(DATA_W / 8);
    localparam int LINE_OFF = WIDX_W + BYTE_OFF;
    localparam int TAG_W    = ADDR_W - LINE_OFF;
    localparam int CNT_W    = WIDX_W + 1;
    localparam int QCNT_W   = $clog2(Q_DEPTH + 1);

    typedef enum logic [1:0] {
        SZ_WORD = 2'd0,
        SZ_HALF = 2'd1,
        SZ_LINE = 2'd2,
        SZ_LALT = 2'd3
    } alloc_size_e;

    typedef enum logic {
        F_IDLE = 1'b0,
        F_RUN  = 1'b1
    } fetch_state_e;

    typedef struct packed {
        logic [ENT_W-1:0]  entry;
        logic [TAG_W-1:0]  tag;
        logic [WIDX_W-1:0] first;
        logic [CNT_W-1:0]  count;
    } fetch_cmd_t;

    // Turn an allocation into an aligned run of words inside one line.
    function automatic fetch_cmd_t build_cmd(
        input logic [ENT_W-1:0]  entry,
        input logic [ADDR_W-1:0] addr,
        input logic [1:0]        size
    );
        fetch_cmd_t        c;
        logic [WIDX_W-1:0] widx;
        logic [WIDX_W-1:0] half_mask;
        widx      = addr[LINE_OFF-1:BYTE_OFF];
        half_mask = WIDX_W'(HALF_WORDS - 1);
        c.entry   = entry;
        c.tag     = addr[ADDR_W-1:LINE_OFF];
        case (alloc_size_e'(size))
            SZ_WORD: begin
                c.first = widx;
                c.count = CNT_W'(1);
            end
            SZ_HALF: begin
                c.first = widx & ~half_mask;
                c.count = CNT_W'(HALF_WORDS);
            end
            default: begin
                c.first = '0;
                c.count = CNT_W'(LINE_WORDS);
            end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/pfrb_cmd_queue.sv
module pfrb_cmd_queue
    import pfrb_pkg::*;
#(
    parameter int DEPTH = Q_DEPTH
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  push,
    input  fetch_cmd_t            cmd_in,
    input  logic                  pop,
    output fetch_cmd_t            cmd_out,
    output logic                  full,
    output logic                  empty,
    output logic [QCNT_W-1:0]     count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    fetch_cmd_t        slots [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [QCNT_W-1:0] cnt_q;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (push) wr_ptr <= ptr_next(wr_ptr);
            if (pop)  rd_ptr <= ptr_next(rd_ptr);
            cnt_q <= cnt_q + QCNT_W'(push) - QCNT_W'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (push) slots[wr_ptr] <= cmd_in;
    end

    assign cmd_out = slots[rd_ptr];
    assign full    = (cnt_q == QCNT_W'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign count   = cnt_q;

endmodule

// File: rtl/pfrb_fetcher.sv
module pfrb_fetcher
    import pfrb_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               q_empty,
    input  fetch_cmd_t         q_cmd,
    output logic               q_pop,
    output logic               clr_en,
    output logic [ENT_W-1:0]   clr_entry,
    output logic [TAG_W-1:0]   clr_tag,
    output logic               mem_req,
    output logic [ADDR_W-1:0]  mem_addr,
    input  logic               mem_rvalid,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic               wr_en,
    output logic [ENT_W-1:0]   wr_entry,
    output logic [WIDX_W-1:0]  wr_widx,
    output logic [DATA_W-1:0]  wr_data
);
    fetch_state_e st_q;
    fetch_cmd_t   cur_q;

    always_comb begin
        q_pop     = (st_q == F_IDLE) && !q_empty;
        clr_en    = q_pop;
        clr_entry = q_cmd.entry;
        clr_tag   = q_cmd.tag;
        mem_req   = (st_q == F_RUN);
        mem_addr  = {cur_q.tag, cur_q.first, {BYTE_OFF{1'b0}}};
        wr_en     = (st_q == F_RUN) && mem_rvalid;
        wr_entry  = cur_q.entry;
        wr_widx   = cur_q.first;
        wr_data   = mem_rdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= F_IDLE;
            cur_q <= '0;
        end else begin
            case (st_q)
                F_IDLE: begin
                    if (q_pop) begin
                        cur_q <= q_cmd;
                        st_q  <= F_RUN;
                    end
                end
                F_RUN: begin
                    if (mem_rvalid) begin
                        cur_q.first <= cur_q.first + WIDX_W'(1);
                        cur_q.count <= cur_q.count - CNT_W'(1);
                        if (cur_q.count == CNT_W'(1)) st_q <= F_IDLE;
                    end
                end
                default: st_q <= F_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pfrb_entry_store.sv
module pfrb_entry_store
    import pfrb_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               clr_en,
    input  logic [ENT_W-1:0]   clr_entry,
    input  logic [TAG_W-1:0]   clr_tag,
    input  logic               wr_en,
    input  logic [ENT_W-1:0]   wr_entry,
    input  logic [WIDX_W-1:0]  wr_widx,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               lk_valid,
    input  logic [ADDR_W-1:0]  lk_addr,
    output logic               rsp_valid,
    output logic               rsp_hit,
    output logic [DATA_W-1:0]  rsp_data
);
    logic [TAG_W-1:0]      tag_q   [N_ENT];
    logic [LINE_WORDS-1:0] valid_q [N_ENT];
    logic [DATA_W-1:0]     data_q  [N_ENT][LINE_WORDS];

    logic [TAG_W-1:0]  lk_tag;
    logic [WIDX_W-1:0] lk_widx;
    logic              hit_c;
    logic [DATA_W-1:0] data_c;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int e = 0; e < N_ENT; e++) begin
                tag_q[e]   <= '0;
                valid_q[e] <= '0;
            end
        end else begin
            for (int e = 0; e < N_ENT; e++) begin
                if (clr_en && clr_entry == ENT_W'(e)) begin
                    tag_q[e]   <= clr_tag;
                    valid_q[e] <= '0;
                end else if (wr_en && wr_entry == ENT_W'(e)) begin
                    valid_q[e][wr_widx] <= 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int e = 0; e < N_ENT; e++) begin
            if (wr_en && wr_entry == ENT_W'(e)) data_q[e][wr_widx] <= wr_data;
        end
    end

    assign lk_tag  = lk_addr[ADDR_W-1:LINE_OFF];
    assign lk_widx = lk_addr[LINE_OFF-1:BYTE_OFF];

    // Lowest numbered matching entry wins.
    always_comb begin
        hit_c  = 1'b0;
        data_c = '0;
        for (int e = N_ENT - 1; e >= 0; e--) begin
            if (tag_q[e] == lk_tag && valid_q[e][lk_widx]) begin
                hit_c  = 1'b1;
                data_c = data_q[e][lk_widx];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= lk_valid;
            rsp_hit   <= lk_valid && hit_c;
            rsp_data  <= lk_valid ? data_c : '0;
        end
    end

endmodule

// File: rtl/pfrb_top.sv
module pfrb_top
    import pfrb_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               alloc_valid,
    input  logic [1:0]         alloc_entry,
    input  logic [31:0]        alloc_addr,
    input  logic [1:0]         alloc_size,
    output logic               alloc_busy,
    input  logic               ld_valid,
    input  logic [31:0]        ld_addr,
    output logic               ld_rsp_valid,
    output logic               ld_hit,
    output logic [31:0]        ld_data,
    output logic               mem_req,
    output logic [31:0]        mem_addr,
    input  logic               mem_rvalid,
    input  logic [31:0]        mem_rdata
);
    fetch_cmd_t         new_cmd, head_cmd;
    logic               q_full, q_empty, q_push, q_pop;
    logic [QCNT_W-1:0]  q_count;
    logic               clr_en, wr_en;
    logic [ENT_W-1:0]   clr_entry, wr_entry;
    logic [TAG_W-1:0]   clr_tag;
    logic [WIDX_W-1:0]  wr_widx;
    logic [DATA_W-1:0]  wr_data;

    assign new_cmd    = build_cmd(alloc_entry, alloc_addr, alloc_size);
    assign q_push     = alloc_valid && !q_full;
    assign alloc_busy = q_full;

    pfrb_cmd_queue #(.DEPTH(Q_DEPTH)) queue_i (
        .clk     (clk),
        .rst     (rst),
        .push    (q_push),
        .cmd_in  (new_cmd),
        .pop     (q_pop),
        .cmd_out (head_cmd),
        .full    (q_full),
        .empty   (q_empty),
        .count   (q_count)
    );

    pfrb_fetcher fetch_i (
        .clk        (clk),
        .rst        (rst),
        .q_empty    (q_empty),
        .q_cmd      (head_cmd),
        .q_pop      (q_pop),
        .clr_en     (clr_en),
        .clr_entry  (clr_entry),
        .clr_tag    (clr_tag),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .wr_en      (wr_en),
        .wr_entry   (wr_entry),
        .wr_widx    (wr_widx),
        .wr_data    (wr_data)
    );

    pfrb_entry_store store_i (
        .clk       (clk),
        .rst       (rst),
        .clr_en    (clr_en),
        .clr_entry (clr_entry),
        .clr_tag   (clr_tag),
        .wr_en     (wr_en),
        .wr_entry  (wr_entry),
        .wr_widx   (wr_widx),
        .wr_data   (wr_data),
        .lk_valid  (ld_valid),
        .lk_addr   (ld_addr),
        .rsp_valid (ld_rsp_valid),
        .rsp_hit   (ld_hit),
        .rsp_data  (ld_data)
    );

endmodule

// File: rtl/pfrb_checker.sv
module pfrb_checker
    import pfrb_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              alloc_valid,
    input logic              alloc_busy,
    input logic              ld_valid,
    input logic              ld_rsp_valid,
    input logic              ld_hit,
    input logic [31:0]       ld_data,
    input logic              mem_req,
    input logic [31:0]       mem_addr,
    input logic              mem_rvalid,
    input logic [QCNT_W-1:0] q_count
);
    logic was_rst;

    always_ff @(posedge clk) begin
        was_rst <= rst;
        if (was_rst && !rst) begin
            a_r1_reset_quiet: assert (!mem_req && !alloc_busy && !ld_rsp_valid)
                else $error("a_r1_reset_quiet");
        end
    end

    a_r8_rsp_next_cycle: assert property (@(posedge clk) disable iff (rst)
        ld_valid |=> ld_rsp_valid);

    a_r8_no_spurious_rsp: assert property (@(posedge clk) disable iff (rst)
        !ld_valid |=> !ld_rsp_valid);

    a_r8_miss_zero_data: assert property (@(posedge clk) disable iff (rst)
        (ld_rsp_valid && !ld_hit) |-> (ld_data == '0));

    a_r13_req_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

    a_r5_word_aligned: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[BYTE_OFF-1:0] == '0));

    a_r10_depth_bound: assert property (@(posedge clk) disable iff (rst)
        q_count <= QCNT_W'(Q_DEPTH));

    a_r10_refused_no_growth: assert property (@(posedge clk) disable iff (rst)
        (alloc_valid && alloc_busy) |=> (q_count <= $past(q_count)));

endmodule

bind pfrb_top pfrb_checker chk_i (
    .clk          (clk),
    .rst          (rst),
    .alloc_valid  (alloc_valid),
    .alloc_busy   (alloc_busy),
    .ld_valid     (ld_valid),
    .ld_rsp_valid (ld_rsp_valid),
    .ld_hit       (ld_hit),
    .ld_data      (ld_data),
    .mem_req      (mem_req),
    .mem_addr     (mem_addr),
    .mem_rvalid   (mem_rvalid),
    .q_count      (q_count)
);

// File: tb/pfrb_top_tb.sv
module pfrb_top_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        alloc_valid;
    logic [1:0]  alloc_entry;
    logic [31:0] alloc_addr;
    logic [1:0]  alloc_size;
    logic        alloc_busy;
    logic        ld_valid;
    logic [31:0] ld_addr;
    logic        ld_rsp_valid;
    logic        ld_hit;
    logic [31:0] ld_data;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid;
    logic [31:0] mem_rdata;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;
    bit mem_hold = 1'b0;

    logic [31:0] exp_addr_q [$];
    string       exp_addr_tag [$];
    logic        exp_hit_q [$];
    logic [31:0] exp_data_q [$];
    string       exp_ld_tag [$];

    always #2.5 clk = ~clk;

    pfrb_top dut_i (
        .clk          (clk),
        .rst          (rst),
        .alloc_valid  (alloc_valid),
        .alloc_entry  (alloc_entry),
        .alloc_addr   (alloc_addr),
        .alloc_size   (alloc_size),
        .alloc_busy   (alloc_busy),
        .ld_valid     (ld_valid),
        .ld_addr      (ld_addr),
        .ld_rsp_valid (ld_rsp_valid),
        .ld_hit       (ld_hit),
        .ld_data      (ld_data),
        .mem_req      (mem_req),
        .mem_addr     (mem_addr),
        .mem_rvalid   (mem_rvalid),
        .mem_rdata    (mem_rdata)
    );

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return {a[31:2], 2'b00} ^ 32'hC3A5_9E17;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Memory model: answers each request after a short wait unless held back,
    // and compares each address against the expected order.
    initial begin
        int wait_cnt;
        wait_cnt   = 0;
        mem_rvalid = 1'b0;
        mem_rdata  = '0;
        forever begin
            @(negedge clk);
            if (mem_rvalid) begin
                mem_rvalid = 1'b0;
                wait_cnt   = 0;
            end else if (mem_req && !mem_hold) begin
                wait_cnt++;
                if (wait_cnt >= 2) begin
                    if (exp_addr_q.size() == 0) begin
                        check(1'b0, "R9 unexpected read", mem_addr, 32'h0);
                    end else begin
                        logic [31:0] ea;
                        string       et;
                        ea = exp_addr_q.pop_front();
                        et = exp_addr_tag.pop_front();
                        check(mem_addr == ea, et, mem_addr, ea);
                    end
                    mem_rdata  = mem_word(mem_addr);
                    mem_rvalid = 1'b1;
                end
            end
        end
    end

    // Load scoreboard monitor.
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && ld_rsp_valid) begin
                if (exp_hit_q.size() == 0) begin
                    check(1'b0, "R8 unexpected response", 32'(ld_hit), 32'h0);
                end else begin
                    logic        eh;
                    logic [31:0] ed;
                    string       et;
                    eh = exp_hit_q.pop_front();
                    ed = exp_data_q.pop_front();
                    et = exp_ld_tag.pop_front();
                    check(ld_hit == eh, {et, " hit"}, 32'(ld_hit), 32'(eh));
                    check(ld_data == ed, {et, " data"}, ld_data, ed);
                end
            end
        end
    end

    task automatic alloc(input int ent, input logic [31:0] a, input logic [1:0] sz,
                         input bit exp_accept, input string req);
        int first;
        int cnt;
        case (sz)
            2'd0:    begin first = int'(a[4:2]);        cnt = 1; end
            2'd1:    begin first = int'(a[4:2]) & 4;    cnt = 4; end
            default: begin first = 0;                   cnt = 8; end
        endcase
        check(alloc_busy == !exp_accept, {req, " busy"}, 32'(alloc_busy), 32'(!exp_accept));
        alloc_valid = 1'b1;
        alloc_entry = 2'(ent);
        alloc_addr  = a;
        alloc_size  = sz;
        if (!alloc_busy) begin
            for (int i = 0; i < cnt; i++) begin
                exp_addr_q.push_back({a[31:5], 5'b0} + 32'((first + i) * 4));
                exp_addr_tag.push_back({req, " fetch address"});
            end
        end
        @(negedge clk);
        alloc_valid = 1'b0;
    endtask

    // Drives one load for one cycle; caller ends a burst with ld_idle.
    task automatic load(input logic [31:0] a, input bit hit, input string req);
        ld_valid = 1'b1;
        ld_addr  = a;
        exp_hit_q.push_back(hit);
        exp_data_q.push_back(hit ? mem_word(a) : 32'h0);
        exp_ld_tag.push_back(req);
        @(negedge clk);
    endtask

    task automatic ld_idle();
        ld_valid = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic drain();
        while (exp_addr_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst         = 1'b1;
        alloc_valid = 1'b0;
        alloc_entry = '0;
        alloc_addr  = '0;
        alloc_size  = '0;
        ld_valid    = 1'b0;
        ld_addr     = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: quiet outputs and nothing valid after reset
        check(!alloc_busy, "R1 busy", 32'(alloc_busy), 32'h0);
        check(!mem_req, "R1 mem_req", 32'(mem_req), 32'h0);
        check(!ld_rsp_valid, "R1 rsp_valid", 32'(ld_rsp_valid), 32'h0);
        load(32'h0000_0000, 1'b0, "R1 empty lookup");
        ld_idle();

        // R4: full line with low bits set, then back-to-back hits (R8)
        alloc(0, 32'h1000_001C, 2'd2, 1'b1, "R4");
        drain();
        for (int w = 0; w < 8; w++) load(32'h1000_0000 + 32'(w * 4), 1'b1, "R8 back-to-back");
        ld_idle();

        // R3: four words from the upper half of a line
        alloc(1, 32'h2000_0038, 2'd1, 1'b1, "R3");
        drain();
        load(32'h2000_0030, 1'b1, "R3 group start");
        load(32'h2000_003C, 1'b1, "R3 group end");
        load(32'h2000_002C, 1'b0, "R6 outside group");
        load(32'h2000_0020, 1'b0, "R6 lower half");
        ld_idle();

        // R5: single word
        alloc(2, 32'h3000_0014, 2'd0, 1'b1, "R5");
        drain();
        load(32'h3000_0016, 1'b1, "R5 word hit");
        load(32'h3000_0010, 1'b0, "R6 neighbour word");
        load(32'h1000_0018, 1'b1, "R11 entry 0 kept");
        ld_idle();

        // R7 and R12: refill entry 2 with memory held back
        mem_hold = 1'b1;
        alloc(2, 32'h3000_0000, 2'd2, 1'b1, "R2 line refill");
        repeat (4) @(negedge clk);
        load(32'h3000_0014, 1'b0, "R7 cleared on start");
        load(32'h3000_001C, 1'b0, "R12 pending word");
        ld_idle();
        mem_hold = 1'b0;
        drain();
        load(32'h3000_001C, 1'b1, "R12 arrived word");
        load(32'h3000_0014, 1'b1, "R12 arrived word 5");
        ld_idle();

        // R10 and R9: fill the queue while memory is held
        mem_hold = 1'b1;
        alloc(3, 32'h4000_0004, 2'd3, 1'b1, "R2 size code 3");
        repeat (3) @(negedge clk);
        alloc(1, 32'h5000_0000, 2'd0, 1'b1, "R9 order a");
        alloc(1, 32'h5000_0004, 2'd0, 1'b1, "R9 order b");
        alloc(1, 32'h5000_0008, 2'd0, 1'b1, "R9 order c");
        alloc(1, 32'h5000_000C, 2'd0, 1'b1, "R9 order d");
        check(alloc_busy, "R10 full flag", 32'(alloc_busy), 32'h1);
        alloc(0, 32'h6000_0000, 2'd2, 1'b0, "R10 refused");
        mem_hold = 1'b0;
        drain();
        load(32'h1000_0004, 1'b1, "R10 refused left entry 0");
        load(32'h6000_0000, 1'b0, "R10 refused line absent");
        load(32'h4000_0010, 1'b1, "R2 code 3 full line");
        load(32'h5000_000C, 1'b1, "R11 last allocation");
        load(32'h5000_0000, 1'b0, "R7 reallocation cleared");
        load(32'h2000_0034, 1'b0, "R11 entry 1 replaced");
        ld_idle();

        check(exp_hit_q.size() == 0, "R8 all loads answered", 32'(exp_hit_q.size()), 32'h0);
        check(exp_addr_q.size() == 0, "R9 all reads seen", 32'(exp_addr_q.size()), 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule